// File: doc/BRIEF.md
# Read-Modify-Write Unary Operation Sequencer

This block executes the unary read-modify-write instructions of an 8-bit processor: increment, decrement, arithmetic shift left, logical shift right, rotate left through carry and rotate right through carry. The instruction fetch logic hands over an opcode with a one-cycle `start` pulse, together with the current program counter, the A, X and Y registers, the carry flag and the page-select flag. The block copies those values at the accepted start. It then runs a fixed bus schedule that depends on the addressing mode.

The register forms act on A, X or Y. They spend one cycle with no bus activity and then write back the new register value. The memory forms first fetch one or two operand bytes at the program counter, pulsing `pc_step` for each one so that the owner of the program counter can advance it. They then read the target byte. In the cycle after that read they write the modified byte back to the same address. The modify step takes place in the write cycle itself. Three memory addressing modes exist: a byte within a 256-byte page, the same with the X register added, and a full 16-bit address. The page-select flag places the page at 0x0000 or at 0x0100.

The memory bus is byte wide and is read without wait states: the read data must be valid in the same cycle as the read strobe. `done` marks the final cycle of every instruction. The register and flag outputs change from the following cycle.

Top module: `rmw_seq`

## Requirements
- R1: After reset, busy, done, mem_rd, mem_wr and pc_step are low, and a_out, x_out, y_out, n_out, z_out and c_out are zero.
- R2: The register forms are 0xBC/0x3D/0xFC (INC A/X/Y), 0x9C/0x1D/0xDC (DEC A/X/Y) and 0x1C/0x5C/0x3C/0x7C (ASL/LSR/ROL/ROR on A). The cycle after an accepted start has no read or write strobe and has done high. The new register value and flags are visible on the outputs in the next cycle.
- R3: INC adds one modulo 256 and DEC subtracts one modulo 256. N becomes result bit 7, Z becomes 1 exactly when the result is zero, and C keeps the carry copied at start.
- R4: ASL shifts left with a zero entering bit 0. LSR shifts right with a zero entering bit 7. ROL moves the old carry into bit 0, and ROR moves the old carry into bit 7. In all four, C takes the bit shifted out (bit 7 for the left shifts, bit 0 for the right shifts), and N and Z come from the result.
- R5: The page forms are 0xAB INC, 0x8B DEC, 0x0B ASL, 0x4B LSR, 0x2B ROL and 0x6B ROR. Cycle 1 after start reads the offset byte at PC, with pc_step high. Cycle 2 reads address 0x0000+offset (P=0) or 0x0100+offset (P=1). Cycle 3 writes the modified byte to that address, with done high.
- R6: The indexed page forms are 0xBB, 0x9B, 0x1B, 0x5B, 0x3B and 0x7B, with the operations in the same order as in R5. Cycle 1 reads the offset at PC, with pc_step high. Cycle 2 has no strobe. Cycle 3 reads the page address whose low byte is (offset+X) mod 256. Cycle 4 writes the result there, with done high.
- R7: The absolute forms are 0xAC, 0x8C, 0x0C, 0x4C, 0x2C and 0x6C, with the operations in the same order as in R5. Cycle 1 reads the low address byte at PC and cycle 2 reads the high address byte at PC+1, each with pc_step high. Cycle 3 reads the target {high,low}. Cycle 4 writes the result there, with done high.
- R8: Memory forms leave a_out, x_out and y_out at the values copied at start. After done, the flags show N, Z and C of the written byte.
- R9: A start pulse while busy is ignored. The inputs are copied only at an accepted start.
- R10: A start with any opcode not listed in R2, R5, R6 or R7 is ignored. busy stays low, no strobe occurs, and all register and flag outputs keep their values.
- R11: done is a single-cycle pulse and busy is low in the cycle after it. mem_rd and mem_wr are never high together, and pc_step is only high together with mem_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the instruction given on opcode |
| opcode | input | 8 | Decoded instruction byte |
| pc_in | input | 16 | Program counter at the first operand byte |
| a_in | input | 8 | Accumulator value at start |
| x_in | input | 8 | X register value at start |
| y_in | input | 8 | Y register value at start |
| c_in | input | 1 | Carry flag at start |
| p_in | input | 1 | Page-select flag at start |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Final cycle of the instruction |
| pc_step | output | 1 | An operand byte is being taken at the program counter |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the read cycle |
| a_out | output | 8 | Accumulator result |
| x_out | output | 8 | X register result |
| y_out | output | 8 | Y register result |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| c_out | output | 1 | Carry flag |

## Verification
Each bus cycle is due at a fixed count after the edge that accepts start. For a register form, done comes 1 cycle later. For a page form, the offset read comes 1 cycle later, the target read 2 cycles later and the write with done 3 cycles later. The indexed and absolute forms are one cycle longer, because of the idle cycle or the second operand read. The driver stamps every expected bus item with its cycle number. It also stamps the register and flag result, which is due one cycle after done. The monitor compares each item only in the cycle whose number it carries, sampling on the falling edge, and flags any item whose cycle has passed without a match.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    OP_INC = 3'd0,
    OP_DEC = 3'd1,
    OP_ASL = 3'd2,
    OP_LSR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5
  } rmw_op_e;

  typedef enum logic [1:0] {
    AM_REG  = 2'd0,
    AM_PAGE = 2'd1,
    AM_PIDX = 2'd2,
    AM_ABS  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    TG_A = 2'd0,
    TG_X = 2'd1,
    TG_Y = 2'd2
  } tgt_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FLO   = 3'd1,
    S_FHI   = 3'd2,
    S_GAP   = 3'd3,
    S_LOAD  = 3'd4,
    S_STORE = 3'd5,
    S_REGOP = 3'd6
  } seq_state_e;

endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
  import rmw_pkg::*;
(
  input  logic [7:0] opcode,
  output logic       valid,
  output amode_e     mode,
  output rmw_op_e    op,
  output tgt_e       tgt
);

  always_comb begin
    valid = 1'b1;
    mode  = AM_REG;
    op    = OP_INC;
    tgt   = TG_A;
    case (opcode)
      // register forms
      8'hBC: begin op = OP_INC; tgt = TG_A; end
      8'h3D: begin op = OP_INC; tgt = TG_X; end
      8'hFC: begin op = OP_INC; tgt = TG_Y; end
      8'h9C: begin op = OP_DEC; tgt = TG_A; end
      8'h1D: begin op = OP_DEC; tgt = TG_X; end
      8'hDC: begin op = OP_DEC; tgt = TG_Y; end
      8'h1C: op = OP_ASL;
      8'h5C: op = OP_LSR;
      8'h3C: op = OP_ROL;
      8'h7C: op = OP_ROR;
      // page
      8'hAB: begin mode = AM_PAGE; op = OP_INC; end
      8'h8B: begin mode = AM_PAGE; op = OP_DEC; end
      8'h0B: begin mode = AM_PAGE; op = OP_ASL; end
      8'h4B: begin mode = AM_PAGE; op = OP_LSR; end
      8'h2B: begin mode = AM_PAGE; op = OP_ROL; end
      8'h6B: begin mode = AM_PAGE; op = OP_ROR; end
      // page indexed by X
      8'hBB: begin mode = AM_PIDX; op = OP_INC; end
      8'h9B: begin mode = AM_PIDX; op = OP_DEC; end
      8'h1B: begin mode = AM_PIDX; op = OP_ASL; end
      8'h5B: begin mode = AM_PIDX; op = OP_LSR; end
      8'h3B: begin mode = AM_PIDX; op = OP_ROL; end
      8'h7B: begin mode = AM_PIDX; op = OP_ROR; end
      // absolute
      8'hAC: begin mode = AM_ABS; op = OP_INC; end
      8'h8C: begin mode = AM_ABS; op = OP_DEC; end
      8'h0C: begin mode = AM_ABS; op = OP_ASL; end
      8'h4C: begin mode = AM_ABS; op = OP_LSR; end
      8'h2C: begin mode = AM_ABS; op = OP_ROL; end
      8'h6C: begin mode = AM_ABS; op = OP_ROR; end
      default: valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int DW = 8
) (
  input  rmw_op_e        op,
  input  logic [DW-1:0]  din,
  input  logic           cin,
  output logic [DW-1:0]  dout,
  output logic           cout,
  output logic           nout,
  output logic           zout
);

  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    dout = din;
    cout = cin;
    case (op)
      OP_INC: dout = din + ONE;
      OP_DEC: dout = din - ONE;
      OP_ASL: begin dout = {din[DW-2:0], 1'b0}; cout = din[DW-1]; end
      OP_LSR: begin dout = {1'b0, din[DW-1:1]}; cout = din[0];    end
      OP_ROL: begin dout = {din[DW-2:0], cin};  cout = din[DW-1]; end
      OP_ROR: begin dout = {cin, din[DW-1:1]};  cout = din[0];    end
      default: ;
    endcase
    nout = dout[DW-1];
    zout = (dout == '0);
  end

endmodule

// File: rtl/rmw_agen.sv
module rmw_agen
  import rmw_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  amode_e         mode,
  input  logic           pg,
  input  logic [DW-1:0]  lo,
  input  logic [DW-1:0]  hi,
  input  logic [DW-1:0]  idx,
  output logic [AW-1:0]  addr
);

  logic [DW-1:0] sum;

  // the index add stays inside DW bits so it wraps within the page
  assign sum = lo + idx;

  always_comb begin
    case (mode)
      AM_PAGE: addr = AW'({pg, lo});
      AM_PIDX: addr = AW'({pg, sum});
      AM_ABS:  addr = AW'({hi, lo});
      default: addr = '0;
    endcase
  end

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  input  logic          c_in,
  input  logic          p_in,
  output logic          busy,
  output logic          done,
  output logic          pc_step,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] x_out,
  output logic [DW-1:0] y_out,
  output logic          n_out,
  output logic          z_out,
  output logic          c_out
);

  localparam logic [AW-1:0] PC_NEXT = AW'(1);

  seq_state_e    st;
  amode_e        mode_q;
  rmw_op_e       op_q;
  tgt_e          tgt_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] lo_q, hi_q, dat_q;
  logic [DW-1:0] a_q, x_q, y_q;
  logic          n_q, z_q, c_q, p_q;

  logic          dec_valid;
  amode_e        dec_mode;
  rmw_op_e       dec_op;
  tgt_e          dec_tgt;

  logic [DW-1:0] alu_in, alu_out;
  logic          alu_c, alu_n, alu_z;
  logic [AW-1:0] tgt_addr;

  rmw_decode u_dec (
    .opcode (opcode),
    .valid  (dec_valid),
    .mode   (dec_mode),
    .op     (dec_op),
    .tgt    (dec_tgt)
  );

  always_comb begin
    alu_in = dat_q;
    if (st == S_REGOP) begin
      case (tgt_q)
        TG_X:    alu_in = x_q;
        TG_Y:    alu_in = y_q;
        default: alu_in = a_q;
      endcase
    end
  end

  rmw_alu #(.DW(DW)) u_alu (
    .op   (op_q),
    .din  (alu_in),
    .cin  (c_q),
    .dout (alu_out),
    .cout (alu_c),
    .nout (alu_n),
    .zout (alu_z)
  );

  rmw_agen #(.DW(DW), .AW(AW)) u_agen (
    .mode (mode_q),
    .pg   (p_q),
    .lo   (lo_q),
    .hi   (hi_q),
    .idx  (x_q),
    .addr (tgt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      mode_q <= AM_REG;
      op_q   <= OP_INC;
      tgt_q  <= TG_A;
      pc_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      dat_q  <= '0;
      a_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      n_q    <= 1'b0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
      p_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start && dec_valid) begin
            mode_q <= dec_mode;
            op_q   <= dec_op;
            tgt_q  <= dec_tgt;
            pc_q   <= pc_in;
            a_q    <= a_in;
            x_q    <= x_in;
            y_q    <= y_in;
            c_q    <= c_in;
            p_q    <= p_in;
            st     <= (dec_mode == AM_REG) ? S_REGOP : S_FLO;
          end
        end
        S_FLO: begin
          lo_q <= mem_rdata;
          case (mode_q)
            AM_PAGE: st <= S_LOAD;
            AM_PIDX: st <= S_GAP;
            default: st <= S_FHI;
          endcase
        end
        S_FHI: begin
          hi_q <= mem_rdata;
          st   <= S_LOAD;
        end
        S_GAP:  st <= S_LOAD;
        S_LOAD: begin
          dat_q <= mem_rdata;
          st    <= S_STORE;
        end
        S_STORE: begin
          n_q <= alu_n;
          z_q <= alu_z;
          c_q <= alu_c;
          st  <= S_IDLE;
        end
        S_REGOP: begin
          case (tgt_q)
            TG_X:    x_q <= alu_out;
            TG_Y:    y_q <= alu_out;
            default: a_q <= alu_out;
          endcase
          n_q <= alu_n;
          z_q <= alu_z;
          c_q <= alu_c;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_FLO:           mem_addr = pc_q;
      S_FHI:           mem_addr = pc_q + PC_NEXT;
      S_LOAD, S_STORE: mem_addr = tgt_addr;
      default:         mem_addr = '0;
    endcase
  end

  assign mem_rd    = (st == S_FLO) || (st == S_FHI) || (st == S_LOAD);
  assign mem_wr    = (st == S_STORE);
  assign mem_wdata = (st == S_STORE) ? alu_out : '0;
  assign pc_step   = (st == S_FLO) || (st == S_FHI);
  assign done      = (st == S_STORE) || (st == S_REGOP);
  assign busy      = (st != S_IDLE);

  assign a_out = a_q;
  assign x_out = x_q;
  assign y_out = y_q;
  assign n_out = n_q;
  assign z_out = z_q;
  assign c_out = c_q;

endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          pc_step,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr
);

  // R11: done lasts one cycle and the block is idle afterwards
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  // R11: read and write strobes are exclusive
  a_r11_no_rd_wr: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R11: operand fetch is always a read
  a_r11_step_is_read: assert property (@(posedge clk) disable iff (rst)
    pc_step |-> mem_rd);

  // R7 (also R5, R6): a write follows a read of the same address and ends the instruction
  a_r7_write_after_read: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($past(mem_rd) && (mem_addr == $past(mem_addr)) && done));

  // R2: a completion without a write uses no bus strobe
  a_r2_reg_quiet: assert property (@(posedge clk) disable iff (rst)
    (done && !mem_wr) |-> (!mem_rd && !pc_step));

endmodule

bind rmw_seq rmw_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .pc_step  (pc_step),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr)
);

// File: tb/rmw_seq_bench.sv
module rmw_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] pc_in = '0;
  logic [7:0]  a_in = '0, x_in = '0, y_in = '0;
  logic        c_in = 1'b0, p_in = 1'b0;
  logic        busy, done, pc_step, mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  a_out, x_out, y_out;
  logic        n_out, z_out, c_out;

  always #5 clk = ~clk;

  rmw_seq u_rmw_seq (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .pc_in(pc_in),
    .a_in(a_in), .x_in(x_in), .y_in(y_in), .c_in(c_in), .p_in(p_in),
    .busy(busy), .done(done), .pc_step(pc_step), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .a_out(a_out), .x_out(x_out), .y_out(y_out),
    .n_out(n_out), .z_out(z_out), .c_out(c_out)
  );

  // memory model: read data follows the address, writes land on the falling edge
  logic [7:0] mem [int];

  function automatic logic [7:0] peek(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    #1 mem_rdata = peek(mem_addr);
  end
  always @(negedge clk) begin
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  typedef struct {
    int          due;
    string       req;
    logic        busy, done, rd, wr, step;
    logic [15:0] addr;
    logic [7:0]  wd;
    bit          fin;
    logic [7:0]  a, x, y;
    logic        n, z, c;
  } item_t;

  item_t q[$];

  logic [7:0] ea = '0, ex = '0, ey = '0;
  logic       en = 1'b0, ez = 1'b0, ec = 1'b0;

  task automatic push(input int due, input string req, input logic b, input logic d,
                      input logic rd, input logic wr, input logic st,
                      input logic [15:0] ad, input logic [7:0] wd, input bit fin);
    item_t it;
    it.due = due; it.req = req; it.busy = b; it.done = d; it.rd = rd; it.wr = wr;
    it.step = st; it.addr = ad; it.wd = wd; it.fin = fin;
    it.a = ea; it.x = ex; it.y = ey; it.n = en; it.z = ez; it.c = ec;
    q.push_back(it);
  endtask

  // monitor: compare each item in the cycle it is due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.due < cyc) chk(it.req, "stale item", 16'(cyc), 16'(it.due));
      else begin
        chk(it.fin ? "R11" : it.req, "busy", 16'(busy), 16'(it.busy));
        chk(it.fin ? "R11" : it.req, "done", 16'(done), 16'(it.done));
        chk(it.req, "mem_rd", 16'(mem_rd), 16'(it.rd));
        chk(it.req, "mem_wr", 16'(mem_wr), 16'(it.wr));
        chk(it.req, "pc_step", 16'(pc_step), 16'(it.step));
        if (it.rd || it.wr) chk(it.req, "mem_addr", mem_addr, it.addr);
        if (it.wr) chk(it.req, "mem_wdata", 16'(mem_wdata), 16'(it.wd));
        if (it.fin) begin
          chk(it.req, "a_out", 16'(a_out), 16'(it.a));
          chk(it.req, "x_out", 16'(x_out), 16'(it.x));
          chk(it.req, "y_out", 16'(y_out), 16'(it.y));
          chk(it.req, "n_out", 16'(n_out), 16'(it.n));
          chk(it.req, "z_out", 16'(z_out), 16'(it.z));
          chk(it.req, "c_out", 16'(c_out), 16'(it.c));
        end
      end
    end
  end

  // reference encoding: mode 0 reg, 1 page, 2 indexed page, 3 absolute
  // op 0 INC, 1 DEC, 2 ASL, 3 LSR, 4 ROL, 5 ROR; target 0 A, 1 X, 2 Y
  function automatic void ref_decode(input logic [7:0] o, output bit ok,
                                     output int md, output int op, output int tg);
    ok = 1'b1; md = 0; op = 0; tg = 0;
    case (o)
      8'hBC: op = 0;
      8'h3D: begin op = 0; tg = 1; end
      8'hFC: begin op = 0; tg = 2; end
      8'h9C: op = 1;
      8'h1D: begin op = 1; tg = 1; end
      8'hDC: begin op = 1; tg = 2; end
      8'h1C: op = 2;
      8'h5C: op = 3;
      8'h3C: op = 4;
      8'h7C: op = 5;
      8'hAB, 8'h8B, 8'h0B, 8'h4B, 8'h2B, 8'h6B,
      8'hBB, 8'h9B, 8'h1B, 8'h5B, 8'h3B, 8'h7B,
      8'hAC, 8'h8C, 8'h0C, 8'h4C, 8'h2C, 8'h6C: begin
        md = (o[3:0] == 4'hC) ? 3 : (o[4] ? 2 : 1);
        case (o[7:5])
          3'd5: op = 0;
          3'd4: op = 1;
          3'd0: op = 2;
          3'd2: op = 3;
          3'd1: op = 4;
          default: op = 5;
        endcase
      end
      default: ok = 1'b0;
    endcase
  endfunction

  function automatic void ref_alu(input int op, input logic [7:0] d, input logic ci,
                                  output logic [7:0] r, output logic co);
    co = ci;
    case (op)
      0: r = d + 8'd1;
      1: r = d - 8'd1;
      2: begin r = {d[6:0], 1'b0}; co = d[7]; end
      3: begin r = {1'b0, d[7:1]}; co = d[0]; end
      4: begin r = {d[6:0], ci};   co = d[7]; end
      default: begin r = {ci, d[7:1]}; co = d[0]; end
    endcase
  endfunction

  // driver: preset memory, start the instruction, push the expected schedule
  task automatic run(input logic [7:0] opc, input logic [7:0] av, input logic [7:0] xv,
                     input logic [7:0] yv, input logic cv, input logic pv,
                     input logic [15:0] pcv, input logic [7:0] o1, input logic [7:0] o2,
                     input logic [7:0] mv, input bit poke);
    bit ok; int md, op, tg, k, len;
    logic [15:0] ad;
    logic [7:0] d, r;
    logic co;
    string rq, fq;
    ref_decode(opc, ok, md, op, tg);
    mem[int'(pcv)] = o1;
    mem[int'(pcv + 16'd1)] = o2;
    ad = (md == 1) ? {7'd0, pv, o1} : (md == 2) ? {7'd0, pv, 8'(o1 + xv)} : {o2, o1};
    if (ok && md != 0) mem[int'(ad)] = mv;
    d = (md != 0) ? mv : (tg == 1) ? xv : (tg == 2) ? yv : av;
    ref_alu(op, d, cv, r, co);
    if (ok) begin
      ea = av; ex = xv; ey = yv;
      if (md == 0) begin
        if (tg == 1) ex = r; else if (tg == 2) ey = r; else ea = r;
      end
      en = r[7]; ez = (r == 8'h00); ec = co;
    end
    @(negedge clk);
    start = 1'b1; opcode = opc; pc_in = pcv;
    a_in = av; x_in = xv; y_in = yv; c_in = cv; p_in = pv;
    k = cyc;
    rq = (md == 0) ? "R2" : (md == 1) ? "R5" : (md == 2) ? "R6" : "R7";
    fq = !ok ? "R10" : poke ? "R9" : (md == 0) ? ((op < 2) ? "R3" : "R4") : "R8";
    if (!ok) begin
      len = 0;
      push(k + 1, "R10", 0, 0, 0, 0, 0, 16'h0, 8'h0, 1'b1);
    end else if (md == 0) begin
      len = 1;
      push(k + 1, rq, 1, 1, 0, 0, 0, 16'h0, 8'h0, 1'b0);
    end else begin
      len = (md == 1) ? 3 : 4;
      push(k + 1, rq, 1, 0, 1, 0, 1, pcv, 8'h0, 1'b0);
      if (md == 2) push(k + 2, rq, 1, 0, 0, 0, 0, 16'h0, 8'h0, 1'b0);
      if (md == 3) push(k + 2, rq, 1, 0, 1, 0, 1, pcv + 16'd1, 8'h0, 1'b0);
      push(k + len - 1, rq, 1, 0, 1, 0, 0, ad, 8'h0, 1'b0);
      push(k + len, rq, 1, 1, 0, 1, 0, ad, r, 1'b0);
    end
    push(k + len + 1, fq, 0, 0, 0, 0, 0, 16'h0, 8'h0, 1'b1);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: a second start mid-instruction with different inputs must be ignored
      start = 1'b1; opcode = 8'hBC; a_in = ~av; x_in = ~xv; c_in = ~cv; p_in = ~pv;
      @(negedge clk);
      start = 1'b0;
    end
    while (cyc <= k + len + 1) @(negedge clk);
  endtask

  logic [7:0] opl [28] = '{8'hBC, 8'h3D, 8'hFC, 8'h9C, 8'h1D, 8'hDC, 8'h1C, 8'h5C,
                           8'h3C, 8'h7C, 8'hAB, 8'h8B, 8'h0B, 8'h4B, 8'h2B, 8'h6B,
                           8'hBB, 8'h9B, 8'h1B, 8'h5B, 8'h3B, 8'h7B, 8'hAC, 8'h8C,
                           8'h0C, 8'h4C, 8'h2C, 8'h6C};
  logic [7:0] pats [6] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h01, 8'hA5};

  bit finished = 1'b0;

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy", 16'(busy), 16'h0);
    chk("R1", "done", 16'(done), 16'h0);
    chk("R1", "mem_rd", 16'(mem_rd), 16'h0);
    chk("R1", "mem_wr", 16'(mem_wr), 16'h0);
    chk("R1", "pc_step", 16'(pc_step), 16'h0);
    chk("R1", "a_out", 16'(a_out), 16'h0);
    chk("R1", "x_out", 16'(x_out), 16'h0);
    chk("R1", "y_out", 16'(y_out), 16'h0);
    chk("R1", "flags", 16'({n_out, z_out, c_out}), 16'h0);

    n = 0;
    for (int i = 0; i < 28; i++) begin
      for (int j = 0; j < 6; j++) begin
        for (int c = 0; c < 2; c++) begin
          run(opl[i], pats[j], pats[j] ^ 8'h3C, ~pats[j], c[0], c[0] ^ pats[j][0],
              16'h8000 + 16'(n * 4), 8'hC0 + 8'(n % 64), 8'h30 + 8'(n % 8),
              pats[j], 1'b0);
          n++;
        end
      end
    end

    // R9: start pulses during busy instructions
    run(8'h2C, 8'h10, 8'h20, 8'h30, 1'b1, 1'b0, 16'h9000, 8'h44, 8'h31, 8'h81, 1'b1);
    run(8'h0B, 8'h10, 8'h20, 8'h30, 1'b0, 1'b1, 16'h9010, 8'h55, 8'h00, 8'hC0, 1'b1);
    run(8'h7B, 8'h10, 8'hF0, 8'h30, 1'b1, 1'b0, 16'h9020, 8'h20, 8'h00, 8'h01, 1'b1);

    // R10: opcodes outside the set are ignored
    run(8'h00, 8'h99, 8'h98, 8'h97, 1'b1, 1'b1, 16'h9100, 8'h10, 8'h00, 8'h00, 1'b0);
    run(8'hEB, 8'h99, 8'h98, 8'h97, 1'b0, 1'b1, 16'h9110, 8'h10, 8'h00, 8'h00, 1'b0);
    run(8'h4D, 8'h99, 8'h98, 8'h97, 1'b1, 1'b0, 16'h9120, 8'h10, 8'h00, 8'h00, 1'b0);

    repeat (2) @(negedge clk);
    chk("R11", "queue drained", 16'(q.size()), 16'h0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule